// File: doc/BRIEF.md
# Integer Multiply/Divide Result Steering Unit

This block is the integer multiply and divide stage of a 64-bit RISC core. Each cycle in which `op_valid_i` is high it takes two register operands, a 3-bit operation code, a 5-bit part-select field and an architecture mode bit. It computes the product or the quotient/remainder in one combinational pass. One clock later it presents registered write-enable pulses and data for the general destination register and for the HI/LO register pair.

The mode bit decides where results go. In paired mode, the signed multiplies and divides send both result halves to HI and LO, and the part-select field is not used. In direct mode, the same operations write only the destination register. The part-select field then picks the low product half or the quotient (value 2), or the high product half or the remainder (value 3). Any other part-select value is refused with an unimplemented flag.

Half-width operations use the low XLEN/2 bits of each operand and sign-extend their results to XLEN. A zero divisor causes no write at all. A signed divide of the most negative value by minus one yields a defined result.

Top module: `mdu_wb`

## Requirements
- R1: While `rst_ni` is low, `rd_we_o`, `hi_we_o`, `lo_we_o` and `unimpl_o` are all 0.
- R2: Each cycle with `op_valid_i` high gives its effects in the next cycle only. After a cycle with `op_valid_i` low, all write enables and `unimpl_o` are 0.
- R3: In paired mode (`direct_mode_i`=0), code 0 (signed half-width multiply) writes the low half of the 2·(XLEN/2)-bit product to LO and the high half to HI. The operands are the low XLEN/2 bits, and each result half is sign-extended to XLEN.
- R4: In direct mode, codes 0 and 2 write only `rd_data_o`: the low product half for part-select 2, the high half for part-select 3. HI and LO are not written.
- R5: Code 2 (signed full-width multiply) forms the 2·XLEN-bit product. Its low XLEN bits are the low half and its high XLEN bits are the high half.
- R6: Codes 3 (signed half-width divide) and 5 (signed full-width divide) truncate toward zero, and the remainder takes the dividend's sign. The quotient goes to LO and the remainder to HI in paired mode. In direct mode, part-select 2 gives the quotient and part-select 3 gives the remainder.
- R7: A signed divide of the most negative value of its width by minus one gives that most negative value as quotient and zero as remainder.
- R8: For codes 3, 4 and 5, a zero divisor (of the operation's width) produces no write and does not raise `unimpl_o`.
- R9: Code 1 (unsigned half-width multiply) and code 4 (unsigned half-width divide) always write HI and LO in both modes, whatever the part-select value. Each result half is sign-extended from bit XLEN/2-1.
- R10: Code 6 writes the sign-extended low half of the signed half-width product to `rd_data_o` in both modes. It never asserts `hi_we_o` or `lo_we_o`.
- R11: Code 7, or direct mode with codes 0, 2, 3 or 5 and a part-select other than 2 or 3, raises `unimpl_o` and suppresses every write. This holds even when the divisor is zero.
- R12: In paired mode the part-select field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| direct_mode_i | input | 1 | 1 = direct-to-register mode, 0 = paired HI/LO mode |
| op_i | input | 3 | Operation code (0..7, see requirements) |
| part_sel_i | input | 5 | Result part select used in direct mode |
| rs_i | input | XLEN | First operand (multiplicand / dividend) |
| rt_i | input | XLEN | Second operand (multiplier / divisor) |
| rd_we_o | output | 1 | Destination register write pulse |
| rd_data_o | output | XLEN | Destination register data |
| hi_we_o | output | 1 | HI register write pulse |
| hi_data_o | output | XLEN | HI register data |
| lo_we_o | output | 1 | LO register write pulse |
| lo_data_o | output | XLEN | LO register data |
| unimpl_o | output | 1 | Unimplemented operation pulse |

## Verification
The bench builds the unit with XLEN=16, so half-width operations run on 8-bit operands. Every product and quotient then fits in ordinary 64-bit bench arithmetic. A 16-value operand set is swept pairwise through every operation code in both modes, with valid, invalid and arbitrary part-select values. The set includes zero, ±1, the most negative and most positive values of both widths, and values whose low half is zero while the full value is not. This reaches both overflow divides, both flavours of zero divisor, and sign extension of unsigned results.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_SMUL_H = 3'd0,
    OP_UMUL_H = 3'd1,
    OP_SMUL_F = 3'd2,
    OP_SDIV_H = 3'd3,
    OP_UDIV_H = 3'd4,
    OP_SDIV_F = 3'd5,
    OP_MUL_RD = 3'd6,
    OP_RSVD   = 3'd7
  } mdu_op_e;

  localparam int unsigned SEL_W = 5;
  localparam logic [SEL_W-1:0] SEL_LOW_PART  = 5'd2;
  localparam logic [SEL_W-1:0] SEL_HIGH_PART = 5'd3;

  typedef enum logic [1:0] {
    DST_PICK = 2'd0,
    DST_PAIR = 2'd1,
    DST_RD   = 2'd2,
    DST_NONE = 2'd3
  } dst_kind_e;

endpackage

// File: rtl/mdu_mult.sv
module mdu_mult #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  mdu_pkg::mdu_op_e op_i,
  output logic [XLEN-1:0]  lo_o,
  output logic [XLEN-1:0]  hi_o
);
  import mdu_pkg::*;

  localparam int unsigned H = XLEN / 2;

  logic [XLEN-1:0]   prod_sh;
  logic [XLEN-1:0]   prod_uh;
  logic [2*XLEN-1:0] prod_sf;

  always_comb begin
    prod_sh = {{H{a_i[H-1]}}, a_i[H-1:0]} * {{H{b_i[H-1]}}, b_i[H-1:0]};
    prod_uh = {{H{1'b0}}, a_i[H-1:0]} * {{H{1'b0}}, b_i[H-1:0]};
    prod_sf = {{XLEN{a_i[XLEN-1]}}, a_i} * {{XLEN{b_i[XLEN-1]}}, b_i};
  end

  always_comb begin
    lo_o = {{H{prod_sh[H-1]}}, prod_sh[H-1:0]};
    hi_o = {{H{prod_sh[XLEN-1]}}, prod_sh[XLEN-1:H]};
    case (op_i)
      OP_UMUL_H: begin
        lo_o = {{H{prod_uh[H-1]}}, prod_uh[H-1:0]};
        hi_o = {{H{prod_uh[XLEN-1]}}, prod_uh[XLEN-1:H]};
      end
      OP_SMUL_F: begin
        lo_o = prod_sf[XLEN-1:0];
        hi_o = prod_sf[2*XLEN-1:XLEN];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  mdu_pkg::mdu_op_e op_i,
  output logic [XLEN-1:0]  quo_o,
  output logic [XLEN-1:0]  rem_o,
  output logic             zero_o
);
  import mdu_pkg::*;

  localparam int unsigned H = XLEN / 2;
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  logic            half_w;
  logic            signed_w;
  logic [XLEN-1:0] dvd;
  logic [XLEN-1:0] dvs;
  logic            dvd_neg;
  logic            dvs_neg;
  logic [XLEN-1:0] mag_a;
  logic [XLEN-1:0] mag_b;
  logic [XLEN-1:0] mag_b_safe;
  logic [XLEN-1:0] uq;
  logic [XLEN-1:0] ur;
  logic [XLEN-1:0] q_full;
  logic [XLEN-1:0] r_full;

  // Operand formatting per width and signedness
  always_comb begin
    half_w   = (op_i == OP_SDIV_H) || (op_i == OP_UDIV_H);
    signed_w = (op_i == OP_SDIV_H) || (op_i == OP_SDIV_F);
    case (op_i)
      OP_SDIV_H: begin
        dvd = {{H{a_i[H-1]}}, a_i[H-1:0]};
        dvs = {{H{b_i[H-1]}}, b_i[H-1:0]};
      end
      OP_UDIV_H: begin
        dvd = {{H{1'b0}}, a_i[H-1:0]};
        dvs = {{H{1'b0}}, b_i[H-1:0]};
      end
      default: begin
        dvd = a_i;
        dvs = b_i;
      end
    endcase
  end

  // One unsigned magnitude divider shared by all divide flavours
  always_comb begin
    dvd_neg    = signed_w & dvd[XLEN-1];
    dvs_neg    = signed_w & dvs[XLEN-1];
    mag_a      = dvd_neg ? (~dvd + ONE) : dvd;
    mag_b      = dvs_neg ? (~dvs + ONE) : dvs;
    zero_o     = (dvs == '0);
    mag_b_safe = zero_o ? ONE : mag_b;
    uq         = mag_a / mag_b_safe;
    ur         = mag_a % mag_b_safe;
    q_full     = (dvd_neg ^ dvs_neg) ? (~uq + ONE) : uq;
    r_full     = dvd_neg ? (~ur + ONE) : ur;
  end

  always_comb begin
    if (half_w) begin
      quo_o = {{H{q_full[H-1]}}, q_full[H-1:0]};
      rem_o = {{H{r_full[H-1]}}, r_full[H-1:0]};
    end else begin
      quo_o = q_full;
      rem_o = r_full;
    end
  end

endmodule

// File: rtl/mdu_route.sv
module mdu_route #(
  parameter int unsigned XLEN = 64
) (
  input  logic                           direct_mode_i,
  input  logic [mdu_pkg::SEL_W-1:0]      part_sel_i,
  input  mdu_pkg::mdu_op_e               op_i,
  input  logic [XLEN-1:0]                mul_lo_i,
  input  logic [XLEN-1:0]                mul_hi_i,
  input  logic [XLEN-1:0]                quo_i,
  input  logic [XLEN-1:0]                rem_i,
  input  logic                           div_zero_i,
  output logic                           rd_we_o,
  output logic                           hi_we_o,
  output logic                           lo_we_o,
  output logic                           unimpl_o,
  output logic [XLEN-1:0]                rd_data_o,
  output logic [XLEN-1:0]                hi_data_o,
  output logic [XLEN-1:0]                lo_data_o
);
  import mdu_pkg::*;

  dst_kind_e       kind;
  logic            blocked;
  logic [XLEN-1:0] part_lo;
  logic [XLEN-1:0] part_hi;
  logic            pick_lo;
  logic            pick_hi;

  // Classify the operation
  always_comb begin
    kind    = DST_PICK;
    blocked = 1'b0;
    part_lo = mul_lo_i;
    part_hi = mul_hi_i;
    case (op_i)
      OP_SMUL_H, OP_SMUL_F: kind = DST_PICK;
      OP_UMUL_H:            kind = DST_PAIR;
      OP_SDIV_H, OP_SDIV_F: begin
        kind    = DST_PICK;
        part_lo = quo_i;
        part_hi = rem_i;
        blocked = div_zero_i;
      end
      OP_UDIV_H: begin
        kind    = DST_PAIR;
        part_lo = quo_i;
        part_hi = rem_i;
        blocked = div_zero_i;
      end
      OP_MUL_RD:            kind = DST_RD;
      default:              kind = DST_NONE;
    endcase
  end

  // Steer results to destinations
  always_comb begin
    pick_lo   = (part_sel_i == SEL_LOW_PART);
    pick_hi   = (part_sel_i == SEL_HIGH_PART);
    rd_we_o   = 1'b0;
    hi_we_o   = 1'b0;
    lo_we_o   = 1'b0;
    unimpl_o  = 1'b0;
    rd_data_o = part_lo;
    hi_data_o = part_hi;
    lo_data_o = part_lo;
    case (kind)
      DST_PICK: begin
        if (!direct_mode_i) begin
          hi_we_o = !blocked;
          lo_we_o = !blocked;
        end else if (pick_lo || pick_hi) begin
          rd_we_o   = !blocked;
          rd_data_o = pick_hi ? part_hi : part_lo;
        end else begin
          unimpl_o = 1'b1;
        end
      end
      DST_PAIR: begin
        hi_we_o = !blocked;
        lo_we_o = !blocked;
      end
      DST_RD:   rd_we_o  = 1'b1;
      default:  unimpl_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/mdu_wb.sv
module mdu_wb #(
  parameter int unsigned XLEN = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      op_valid_i,
  input  logic                      direct_mode_i,
  input  logic [2:0]                op_i,
  input  logic [mdu_pkg::SEL_W-1:0] part_sel_i,
  input  logic [XLEN-1:0]           rs_i,
  input  logic [XLEN-1:0]           rt_i,
  output logic                      rd_we_o,
  output logic [XLEN-1:0]           rd_data_o,
  output logic                      hi_we_o,
  output logic [XLEN-1:0]           hi_data_o,
  output logic                      lo_we_o,
  output logic [XLEN-1:0]           lo_data_o,
  output logic                      unimpl_o
);
  import mdu_pkg::*;

  mdu_op_e         op;
  logic [XLEN-1:0] mul_lo;
  logic [XLEN-1:0] mul_hi;
  logic [XLEN-1:0] quo;
  logic [XLEN-1:0] rem;
  logic            div_zero;
  logic            r_rd_we;
  logic            r_hi_we;
  logic            r_lo_we;
  logic            r_unimpl;
  logic [XLEN-1:0] r_rd_data;
  logic [XLEN-1:0] r_hi_data;
  logic [XLEN-1:0] r_lo_data;

  logic            rd_we_d, hi_we_d, lo_we_d, unimpl_d;
  logic            rd_en, hi_en, lo_en;
  logic            rd_we_q, hi_we_q, lo_we_q, unimpl_q;
  logic [XLEN-1:0] rd_data_q, hi_data_q, lo_data_q;

  assign op = mdu_op_e'(op_i);

  mdu_mult #(.XLEN(XLEN)) u_mult (
    .a_i  (rs_i),
    .b_i  (rt_i),
    .op_i (op),
    .lo_o (mul_lo),
    .hi_o (mul_hi)
  );

  mdu_div #(.XLEN(XLEN)) u_div (
    .a_i    (rs_i),
    .b_i    (rt_i),
    .op_i   (op),
    .quo_o  (quo),
    .rem_o  (rem),
    .zero_o (div_zero)
  );

  mdu_route #(.XLEN(XLEN)) u_route (
    .direct_mode_i (direct_mode_i),
    .part_sel_i    (part_sel_i),
    .op_i          (op),
    .mul_lo_i      (mul_lo),
    .mul_hi_i      (mul_hi),
    .quo_i         (quo),
    .rem_i         (rem),
    .div_zero_i    (div_zero),
    .rd_we_o       (r_rd_we),
    .hi_we_o       (r_hi_we),
    .lo_we_o       (r_lo_we),
    .unimpl_o      (r_unimpl),
    .rd_data_o     (r_rd_data),
    .hi_data_o     (r_hi_data),
    .lo_data_o     (r_lo_data)
  );

  // Next state: pulses only for a presented operation
  always_comb begin
    rd_we_d  = op_valid_i & r_rd_we;
    hi_we_d  = op_valid_i & r_hi_we;
    lo_we_d  = op_valid_i & r_lo_we;
    unimpl_d = op_valid_i & r_unimpl;
    rd_en    = rd_we_d;
    hi_en    = hi_we_d;
    lo_en    = lo_we_d;
  end

  // Control registers with asynchronous reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_we_q  <= 1'b0;
      hi_we_q  <= 1'b0;
      lo_we_q  <= 1'b0;
      unimpl_q <= 1'b0;
    end else begin
      rd_we_q  <= rd_we_d;
      hi_we_q  <= hi_we_d;
      lo_we_q  <= lo_we_d;
      unimpl_q <= unimpl_d;
    end
  end

  // Data registers: loaded only when their write is issued
  always_ff @(posedge clk_i) begin
    if (rd_en) rd_data_q <= r_rd_data;
    if (hi_en) hi_data_q <= r_hi_data;
    if (lo_en) lo_data_q <= r_lo_data;
  end

  assign rd_we_o   = rd_we_q;
  assign hi_we_o   = hi_we_q;
  assign lo_we_o   = lo_we_q;
  assign unimpl_o  = unimpl_q;
  assign rd_data_o = rd_data_q;
  assign hi_data_o = hi_data_q;
  assign lo_data_o = lo_data_q;

endmodule

// File: rtl/mdu_wb_chk.sv
module mdu_wb_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            op_valid_i,
  input logic            direct_mode_i,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] rs_i,
  input logic [XLEN-1:0] rt_i,
  input logic            rd_we_o,
  input logic            hi_we_o,
  input logic [XLEN-1:0] hi_data_o,
  input logic            lo_we_o,
  input logic [XLEN-1:0] lo_data_o,
  input logic            unimpl_o
);
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !(rd_we_o || hi_we_o || lo_we_o || unimpl_o));

  a_r3_pair_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_o |-> (lo_we_o && !rd_we_o));

  a_r3_pair_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_o |-> hi_we_o);

  a_r4_direct_no_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && direct_mode_i && (op_i == 3'd0 || op_i == 3'd2)) |=> (!hi_we_o && !lo_we_o));

  a_r7_full_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !direct_mode_i && op_i == 3'd5 && rs_i == MOST_NEG && rt_i == '1)
      |=> (lo_we_o && lo_data_o == MOST_NEG && hi_data_o == '0));

  a_r8_zero_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !direct_mode_i && op_i == 3'd5 && rt_i == '0)
      |=> !(rd_we_o || hi_we_o || lo_we_o || unimpl_o));

  a_r9_unsigned_mul_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd1) |=> (hi_we_o && lo_we_o && !rd_we_o));

  a_r10_rd_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd6) |=> (rd_we_o && !hi_we_o && !lo_we_o));

  a_r11_unimpl_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unimpl_o |-> !(rd_we_o || hi_we_o || lo_we_o));

  a_r11_reserved_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd7) |=> unimpl_o);

  a_r12_paired_ignores_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !direct_mode_i && op_i == 3'd0) |=> (hi_we_o && lo_we_o));

endmodule

bind mdu_wb mdu_wb_chk #(.XLEN(XLEN)) u_mdu_wb_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .op_valid_i    (op_valid_i),
  .direct_mode_i (direct_mode_i),
  .op_i          (op_i),
  .rs_i          (rs_i),
  .rt_i          (rt_i),
  .rd_we_o       (rd_we_o),
  .hi_we_o       (hi_we_o),
  .hi_data_o     (hi_data_o),
  .lo_we_o       (lo_we_o),
  .lo_data_o     (lo_data_o),
  .unimpl_o      (unimpl_o)
);

// File: tb/mdu_wb_bench.sv
module mdu_wb_bench;
  localparam int XL = 16;
  localparam int HL = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid;
  logic          direct_mode;
  logic [2:0]    op;
  logic [4:0]    part_sel;
  logic [XL-1:0] rs;
  logic [XL-1:0] rt;
  logic          rd_we, hi_we, lo_we, unimpl;
  logic [XL-1:0] rd_data, hi_data, lo_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  mdu_wb #(.XLEN(XL)) u_mdu_wb (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .op_valid_i    (op_valid),
    .direct_mode_i (direct_mode),
    .op_i          (op),
    .part_sel_i    (part_sel),
    .rs_i          (rs),
    .rt_i          (rt),
    .rd_we_o       (rd_we),
    .rd_data_o     (rd_data),
    .hi_we_o       (hi_we),
    .hi_data_o     (hi_data),
    .lo_we_o       (lo_we),
    .lo_data_o     (lo_data),
    .unimpl_o      (unimpl)
  );

  always #5 clk = ~clk;

  function automatic longint sx(longint x, int w);
    longint v;
    v = x & ((longint'(1) << w) - 1);
    if (v[w-1]) v = v - (longint'(1) << w);
    return v;
  endfunction

  function automatic logic [XL-1:0] pick(int i);
    case (i)
      0:  return 16'h0000;
      1:  return 16'h0001;
      2:  return 16'hffff;
      3:  return 16'h0002;
      4:  return 16'hfffe;
      5:  return 16'h0007;
      6:  return 16'hfff9;
      7:  return 16'h8000;
      8:  return 16'h7fff;
      9:  return 16'h0080;
      10: return 16'h00ff;
      11: return 16'h007f;
      12: return 16'h1234;
      13: return 16'hfedc;
      14: return 16'h0100;
      default: return 16'h8001;
    endcase
  endfunction

  task automatic model(input int opc, input bit md, input logic [4:0] sel,
                       input logic [XL-1:0] a, input logic [XL-1:0] b,
                       output bit e_rd, output bit e_hi, output bit e_lo, output bit e_un,
                       output logic [XL-1:0] v_rd, output logic [XL-1:0] v_hi,
                       output logic [XL-1:0] v_lo, output string tag);
    longint sa8, sb8, ua8, ub8, fa, fb, p, q, r, lo_l, hi_l;
    int kind;
    bit zero, ovf;
    sa8 = sx(longint'(a), HL);  sb8 = sx(longint'(b), HL);
    ua8 = longint'(a[HL-1:0]);  ub8 = longint'(b[HL-1:0]);
    fa  = sx(longint'(a), XL);  fb  = sx(longint'(b), XL);
    lo_l = 0; hi_l = 0; zero = 1'b0; ovf = 1'b0; kind = 0;
    case (opc)
      0: begin p = sa8 * sb8; lo_l = sx(p, HL); hi_l = sx(p >>> HL, HL); kind = 0; end
      1: begin p = ua8 * ub8; lo_l = sx(p, HL); hi_l = sx(p >>> HL, HL); kind = 1; end
      2: begin p = fa * fb;   lo_l = p;         hi_l = p >>> XL;         kind = 0; end
      3: begin
        zero = (sb8 == 0);
        ovf  = (sa8 == -(longint'(1) << (HL-1))) && (sb8 == -1);
        if (!zero) begin q = sa8 / sb8; r = sa8 % sb8; lo_l = sx(q, HL); hi_l = sx(r, HL); end
        kind = 0;
      end
      4: begin
        zero = (ub8 == 0);
        if (!zero) begin q = ua8 / ub8; r = ua8 % ub8; lo_l = sx(q, HL); hi_l = sx(r, HL); end
        kind = 1;
      end
      5: begin
        zero = (fb == 0);
        ovf  = (fa == -(longint'(1) << (XL-1))) && (fb == -1);
        if (!zero) begin q = fa / fb; r = fa % fb; lo_l = q; hi_l = r; end
        kind = 0;
      end
      6: begin lo_l = sx(sa8 * sb8, HL); kind = 2; end
      default: kind = 3;
    endcase
    e_rd = 1'b0; e_hi = 1'b0; e_lo = 1'b0; e_un = 1'b0;
    v_rd = XL'(lo_l); v_hi = XL'(hi_l); v_lo = XL'(lo_l);
    case (kind)
      0: begin
        if (!md) begin
          e_hi = !zero; e_lo = !zero;
        end else if (sel == 5'd2 || sel == 5'd3) begin
          e_rd = !zero;
          v_rd = (sel == 5'd3) ? XL'(hi_l) : XL'(lo_l);
        end else begin
          e_un = 1'b1;
        end
      end
      1: begin e_hi = !zero; e_lo = !zero; end
      2: e_rd = 1'b1;
      default: e_un = 1'b1;
    endcase
    if (e_un)                       tag = "R11";
    else if (zero)                  tag = "R8";
    else if (ovf)                   tag = "R7";
    else if (opc == 2)              tag = "R5";
    else if (opc == 6)              tag = "R10";
    else if (opc == 1 || opc == 4)  tag = "R9";
    else if (md && opc == 0)        tag = "R4";
    else if (opc == 3 || opc == 5)  tag = "R6";
    else if (sel != 5'd0)           tag = "R12";
    else                            tag = "R3";
  endtask

  task automatic run_op(input int opc, input bit md, input logic [4:0] sel,
                        input logic [XL-1:0] a, input logic [XL-1:0] b);
    bit e_rd, e_hi, e_lo, e_un, bad;
    logic [XL-1:0] v_rd, v_hi, v_lo;
    string tag;
    model(opc, md, sel, a, b, e_rd, e_hi, e_lo, e_un, v_rd, v_hi, v_lo, tag);
    @(negedge clk);
    op = 3'(opc); direct_mode = md; part_sel = sel; rs = a; rt = b; op_valid = 1'b1;
    @(negedge clk);
    checks++;
    bad = (rd_we !== e_rd) || (hi_we !== e_hi) || (lo_we !== e_lo) || (unimpl !== e_un) ||
          (e_rd && rd_data !== v_rd) || (e_hi && hi_data !== v_hi) || (e_lo && lo_data !== v_lo);
    if (bad) begin
      fails++;
      $display("FAIL %s op=%0d mode=%0d sel=%0d rs=%h rt=%h actual we(rd,hi,lo,un)=%b%b%b%b rd=%h hi=%h lo=%h expected we=%b%b%b%b rd=%h hi=%h lo=%h",
               tag, opc, md, sel, a, b, rd_we, hi_we, lo_we, unimpl, rd_data, hi_data, lo_data,
               e_rd, e_hi, e_lo, e_un, v_rd, v_hi, v_lo);
    end
    op_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (rd_we || hi_we || lo_we || unimpl) begin
      fails++;
      $display("FAIL R2 idle cycle actual we(rd,hi,lo,un)=%b%b%b%b expected 0000",
               rd_we, hi_we, lo_we, unimpl);
    end
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; direct_mode = 1'b0; op = '0; part_sel = '0;
    rs = '0; rt = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_we || hi_we || lo_we || unimpl) begin
      fails++;
      $display("FAIL R1 reset actual we(rd,hi,lo,un)=%b%b%b%b expected 0000",
               rd_we, hi_we, lo_we, unimpl);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        for (int k = 0; k < 8; k++)
          run_op(k, 1'b0, 5'((i * 7 + j + k) % 32), pick(i), pick(j));
        for (int k = 0; k < 8; k++) begin
          if (k == 0 || k == 2 || k == 3 || k == 5) begin
            run_op(k, 1'b1, 5'd2, pick(i), pick(j));
            run_op(k, 1'b1, 5'd3, pick(i), pick(j));
          end
          run_op(k, 1'b1, 5'((i * 3 + j * 5 + k) % 32), pick(i), pick(j));
        end
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired before sweep completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule